// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a segment-relative memory reference into a 20-bit physical address. It holds four 16-bit segment base registers: code, stack, data and extra data. It also holds the instruction pointer and the stack pointer. Each request names an access role. The block picks the matching base, shifts it left by four bit positions and adds a 16-bit offset. The sum wraps modulo 2^20.

The four roles are:
- instruction fetch, which uses the code base with the instruction pointer;
- stack push, which uses the stack base with the stack pointer;
- stack pop, which uses the stack base with the stack pointer;
- data access, which uses the data base, or the extra base when the override is set, with an offset supplied by the request.

A fetch also carries the length of the instruction in bytes, and the instruction pointer advances by that amount. A push pre-decrements the stack pointer by two. A pop post-increments it by two. All pointer arithmetic wraps inside 16 bits.

A write port loads any of the six registers. The result is registered and appears one clock after the request, together with a valid strobe.

Top module: `segaddr_gen`

## Requirements
- R1: While reset is asserted and after its release, all six registers are zero and addr_valid is low, so the first fetch yields address 0x00000.
- R2: A fetch (req_kind 2'b00) produces code_base*16 + instruction pointer, truncated to 20 bits.
- R3: After a fetch, the instruction pointer equals its old value plus req_ilen, modulo 2^16.
- R4: A push (req_kind 2'b01) first lowers the stack pointer by 2, modulo 2^16. The address is then stack_base*16 plus the lowered pointer.
- R5: A pop (req_kind 2'b10) produces stack_base*16 plus the current stack pointer. The pointer is then raised by 2, modulo 2^16.
- R6: A data access (req_kind 2'b11) uses the data base when req_alt_seg is 0 and the extra base when it is 1, with req_offset as the offset.
- R7: The physical address sum wraps modulo 2^20. For example, base 0xFFFF with offset 0x0020 gives 0x00010.
- R8: addr_out and addr_valid update on the clock edge that samples the request. addr_valid is high for exactly the cycles that follow a cycle with req_valid high.
- R9: wr_sel selects the register that wr_data loads: 0 code, 1 stack, 2 data, 3 extra, 4 instruction pointer, 5 stack pointer. A request in the same cycle uses the old register values. A write to a pointer takes precedence over that request's pointer update.
- R10: A write with wr_sel 6 or 7 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 00 fetch, 01 push, 10 pop, 11 data |
| req_alt_seg | input | 1 | Data access uses the extra base instead of the data base |
| req_offset | input | 16 | Offset for data accesses |
| req_ilen | input | 4 | Instruction length in bytes, used on a fetch |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register selector for the write |
| wr_data | input | 16 | Value to load |
| addr_out | output | 20 | Registered physical address |
| addr_valid | output | 1 | addr_out holds a new address this cycle |

## Verification
Every address is due one clock after the request that forms it. Stimulus is driven on the falling edge. The bench samples addr_out and addr_valid on the next falling edge, after exactly one rising edge has captured the result.

Pointer effects (R3, R4, R5, R9) are not visible as a separate output. They show up in the address of the next request that uses that pointer, so they are checked one request later. The bench also checks that addr_valid drops on the falling edge after an idle cycle.

// File: rtl/segaddr_gen.sv
module segaddr_gen #(
  parameter int SEG_W  = 16,
  parameter int OFS_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ILEN_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [1:0]             req_kind,
  input  logic                   req_alt_seg,
  input  logic [OFS_W-1:0]       req_offset,
  input  logic [ILEN_W-1:0]      req_ilen,
  input  logic                   wr_en,
  input  logic [2:0]             wr_sel,
  input  logic [OFS_W-1:0]       wr_data,
  output logic [SEG_W+SHIFT-1:0] addr_out,
  output logic                   addr_valid
);
  localparam int PA_W = SEG_W + SHIFT;

  logic [SEG_W-1:0] code_q, stk_q, dat_q, ext_q;
  logic [OFS_W-1:0] ip_q, sp_q;
  logic [SEG_W-1:0] base;
  logic [OFS_W-1:0] ofs;

  wire is_fetch = req_valid && req_kind == 2'b00;
  wire is_push  = req_valid && req_kind == 2'b01;
  wire is_pop   = req_valid && req_kind == 2'b10;

  wire [OFS_W-1:0] sp_dn  = sp_q - OFS_W'(2);
  wire [OFS_W-1:0] sp_up  = sp_q + OFS_W'(2);
  wire [OFS_W-1:0] ip_adv = ip_q + OFS_W'(req_ilen);

  wire [SEG_W-1:0] wdat_seg = SEG_W'(wr_data);

  always_comb begin
    case (req_kind)
      2'b00: begin base = code_q; ofs = ip_q;  end
      2'b01: begin base = stk_q;  ofs = sp_dn; end
      2'b10: begin base = stk_q;  ofs = sp_q;  end
      default: begin
        base = req_alt_seg ? ext_q : dat_q;
        ofs  = req_offset;
      end
    endcase
  end

  wire [PA_W-1:0] phys = {base, {SHIFT{1'b0}}} + PA_W'(ofs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      stk_q  <= '0;
      dat_q  <= '0;
      ext_q  <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        3'd0: code_q <= wdat_seg;
        3'd1: stk_q  <= wdat_seg;
        3'd2: dat_q  <= wdat_seg;
        3'd3: ext_q  <= wdat_seg;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ip_q <= '0;
    else if (wr_en && wr_sel == 3'd4) ip_q <= wr_data;
    else if (is_fetch) ip_q <= ip_adv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else if (wr_en && wr_sel == 3'd5) sp_q <= wr_data;
    else if (is_push) sp_q <= sp_dn;
    else if (is_pop) sp_q <= sp_up;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_out   <= '0;
      addr_valid <= 1'b0;
    end else begin
      addr_valid <= req_valid;
      if (req_valid) addr_out <= phys;
    end
  end
endmodule

module segaddr_gen_chk #(
  parameter int OFS_W  = 16,
  parameter int ILEN_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_kind,
  input logic [ILEN_W-1:0] req_ilen,
  input logic              wr_en,
  input logic [2:0]        wr_sel,
  input logic [OFS_W-1:0]  wr_data,
  input logic [OFS_W-1:0]  ip_q,
  input logic [OFS_W-1:0]  sp_q,
  input logic              addr_valid
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !addr_valid);

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> addr_valid);

  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !addr_valid);

  // R3
  ip_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'b00 && !(wr_en && wr_sel == 3'd4))
    |=> ip_q == OFS_W'($past(ip_q) + OFS_W'($past(req_ilen))));

  // R4
  push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'b01 && !(wr_en && wr_sel == 3'd5))
    |=> sp_q == OFS_W'($past(sp_q) - OFS_W'(2)));

  // R5
  pop_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'b10 && !(wr_en && wr_sel == 3'd5))
    |=> sp_q == OFS_W'($past(sp_q) + OFS_W'(2)));

  // R9
  ip_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd4) |=> ip_q == $past(wr_data));

  // R10
  stray_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel > 3'd5 && !req_valid) |=> ($stable(ip_q) && $stable(sp_q)));
endmodule

bind segaddr_gen segaddr_gen_chk #(.OFS_W(OFS_W), .ILEN_W(ILEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .req_ilen(req_ilen), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .ip_q(ip_q), .sp_q(sp_q), .addr_valid(addr_valid)
);

// File: tb/segaddr_gen_bench.sv
module segaddr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'b00;
  logic        req_alt_seg = 1'b0;
  logic [15:0] req_offset = '0;
  logic [3:0]  req_ilen = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [19:0] addr_out;
  logic        addr_valid;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  segaddr_gen u_segaddr_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_alt_seg(req_alt_seg), .req_offset(req_offset), .req_ilen(req_ilen),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .addr_out(addr_out), .addr_valid(addr_valid)
  );

  task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %05h expected %05h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic req(input string tag, input logic [1:0] k, input logic alt,
                     input logic [15:0] ofs, input logic [3:0] il,
                     input logic [19:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_alt_seg = alt; req_offset = ofs; req_ilen = il;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R8 valid"}, 20'(addr_valid), 20'd1);
    chk(tag, addr_out, exp);
  endtask

  task automatic t_reset;
    chk("R1 valid low in reset", 20'(addr_valid), 20'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid low after reset", 20'(addr_valid), 20'd0);
    req("R1 first fetch", 2'b00, 1'b0, 16'h0, 4'd3, 20'h00000);
    req("R3 ip advanced from zero", 2'b00, 1'b0, 16'h0, 4'd0, 20'h00003);
  endtask

  task automatic t_fetch;
    wr(3'd0, 16'h1234);
    wr(3'd4, 16'h0010);
    req("R2 fetch", 2'b00, 1'b0, 16'h0, 4'd5, 20'h12350);
    req("R3 ip +5", 2'b00, 1'b0, 16'h0, 4'd0, 20'h12355);
    wr(3'd4, 16'hFFFE);
    req("R2 fetch high ip", 2'b00, 1'b0, 16'h0, 4'd4, 20'h2233E);
    req("R3 ip wraps 16 bits", 2'b00, 1'b0, 16'h0, 4'd0, 20'h12342);
  endtask

  task automatic t_wrap;
    wr(3'd0, 16'hFFFF);
    wr(3'd4, 16'h0020);
    req("R7 address wraps", 2'b00, 1'b0, 16'h0, 4'd0, 20'h00010);
  endtask

  task automatic t_stack;
    wr(3'd1, 16'h2000);
    wr(3'd5, 16'h0100);
    req("R4 push 1", 2'b01, 1'b0, 16'h0, 4'd0, 20'h200FE);
    req("R4 push 2", 2'b01, 1'b0, 16'h0, 4'd0, 20'h200FC);
    req("R5 pop 1", 2'b10, 1'b0, 16'h0, 4'd0, 20'h200FC);
    req("R5 pop 2", 2'b10, 1'b0, 16'h0, 4'd0, 20'h200FE);
    req("R5 pop 3 sp raised", 2'b10, 1'b0, 16'h0, 4'd0, 20'h20100);
    wr(3'd5, 16'h0000);
    req("R4 push wraps sp", 2'b01, 1'b0, 16'h0, 4'd0, 20'h2FFFE);
    req("R5 pop at FFFE", 2'b10, 1'b0, 16'h0, 4'd0, 20'h2FFFE);
    req("R5 sp wrapped to 0", 2'b10, 1'b0, 16'h0, 4'd0, 20'h20000);
  endtask

  task automatic t_data;
    wr(3'd2, 16'h3000);
    wr(3'd3, 16'h4000);
    req("R6 data base", 2'b11, 1'b0, 16'h0ABC, 4'd0, 20'h30ABC);
    req("R6 extra base", 2'b11, 1'b1, 16'h0ABC, 4'd0, 20'h40ABC);
    req("R7 data wrap", 2'b11, 1'b0, 16'hFFFF, 4'd0, 20'h3FFFF);
  endtask

  task automatic t_valid;
    @(negedge clk);
    chk("R8 valid drops when idle", 20'(addr_valid), 20'd0);
  endtask

  task automatic t_priority;
    wr(3'd0, 16'h0000);
    wr(3'd4, 16'h0050);
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'b00; req_ilen = 4'd2;
    wr_en = 1'b1; wr_sel = 3'd4; wr_data = 16'h0100;
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b0;
    chk("R9 same-cycle fetch uses old ip", addr_out, 20'h00050);
    req("R9 write wins over advance", 2'b00, 1'b0, 16'h0, 4'd0, 20'h00100);
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'b11; req_alt_seg = 1'b0; req_offset = 16'h0001;
    wr_en = 1'b1; wr_sel = 3'd2; wr_data = 16'h5000;
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b0;
    chk("R9 same-cycle data uses old base", addr_out, 20'h30001);
    req("R9 data base loaded", 2'b11, 1'b0, 16'h0001, 4'd0, 20'h50001);
  endtask

  task automatic t_ignore;
    wr(3'd6, 16'hFFFF);
    wr(3'd7, 16'hABCD);
    req("R10 ip untouched", 2'b00, 1'b0, 16'h0, 4'd0, 20'h00100);
    req("R10 data base untouched", 2'b11, 1'b0, 16'h0000, 4'd0, 20'h50000);
    req("R10 extra base untouched", 2'b11, 1'b1, 16'h0000, 4'd0, 20'h40000);
    req("R10 stack untouched", 2'b10, 1'b0, 16'h0, 4'd0, 20'h20002);
  endtask

  initial begin
    t_reset;
    t_fetch;
    t_wrap;
    t_stack;
    t_data;
    t_valid;
    t_priority;
    t_ignore;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule